// File: doc/BRIEF.md
# Supply Reset Supervisor with Watchdog

This block produces the active-low system reset for a host processor. It watches a digital supply-good signal from an external comparator, a flag saying that the chip is running from its backup cell, and a watchdog that the host must service. Reset falls as soon as the supply is seen below threshold. It rises again only after the supply has been good, with the chip back on main power, for a fixed hold time. The default hold time is 8192 ticks of a 32.768 kHz clock, which is 250 ms.

The watchdog limit is chosen from three timeouts in the ratio 1:3:7 of a base unit, or the watchdog can be switched off. A missed service produces a reset pulse as long as the hold time. The watchdog is frozen while the chip runs from the backup cell.

The block also passes the 3-bit threshold selection on to the comparator, folding the unused codes onto the lowest level. It gates the serial-bus enable while reset is low, unless an override bit is set.

Top module: `rsv_supervisor`

## Requirements
- R1: `thr_level` equals `thr_sel` for codes 0 to 4. For codes 5, 6 and 7 it is 0, which is the lowest level.
- R2: A clock edge that samples `supply_ok`=0 drives `rst_out_n` low after that edge. It also cancels any watchdog pulse and clears the watchdog count.
- R3: After `arst_n` and after any dip, `rst_out_n` stays low. It rises after the HOLD_CYC-th consecutive edge that samples `supply_ok`=1 and `on_battery`=0. Any other sample restarts the count.
- R4: While reset is held, `on_battery`=1 prevents release even when `supply_ok`=1, and it restarts the hold count.
- R5: `wd_mode` selects the watchdog timeout: 00 is off, 01 is 1×WD_UNIT, 10 is 3×WD_UNIT and 11 is 7×WD_UNIT. The watchdog fires on the edge that completes that many consecutive enabled edges with no service, counted from release or from the last restart.
- R6: While `on_battery`=1 or `wd_mode`=00 with reset released, the watchdog never fires, its count is cleared, and `rst_out_n` stays high.
- R7: `wd_kick`=1 sampled at an edge restarts the watchdog count. A kick on the edge that would have expired the watchdog wins, and no pulse follows.
- R8: A watchdog expiry drives `rst_out_n` low for exactly HOLD_CYC cycles. Kicks are ignored during the pulse, and counting restarts from zero after it.
- R9: `bus_en` is 1 while `rst_out_n` is 1. While reset is low, `bus_en` equals `bus_ovr`.
- R10: A supply dip on the same edge as a watchdog expiry is handled as a dip. After recovery, release follows the normal HOLD_CYC count, with no extra pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timebase clock (32.768 kHz in use) |
| arst_n | input | 1 | Asynchronous core reset, active low |
| supply_ok | input | 1 | Comparator output, 1 when supply is above the threshold |
| on_battery | input | 1 | 1 while the chip runs from the backup cell |
| thr_sel | input | THR_W | Threshold selection code |
| thr_level | output | THR_W | Threshold level sent to the comparator |
| wd_mode | input | 2 | Watchdog timeout selection |
| wd_kick | input | 1 | Watchdog service strobe |
| bus_ovr | input | 1 | Keeps the serial bus enabled during reset |
| rst_out_n | output | 1 | System reset, active low |
| bus_en | output | 1 | Serial-bus enable |

## Verification
A watchdog expiry can land on the same edge as a service strobe, or on the same edge as a supply dip. The bench runs the watchdog to the cycle just before expiry. It then raises `wd_kick` or drops `supply_ok` for exactly the expiring edge, and judges the result against the rule for that case. A kick must leave reset high. A dip must produce only the normal hold release and no extra pulse. A behavioural model compares every cycle of those runs, and of a long random run, so the same collisions are also met at arbitrary counts.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

   typedef enum logic [1:0] {
      WD_OFF   = 2'b00,
      WD_SHORT = 2'b01,
      WD_MID   = 2'b10,
      WD_LONG  = 2'b11
   } wd_mode_e;

   // Timeout multiplier for a mode code: 0, 1, 3, 7
   function automatic int unsigned wd_mult(input int unsigned code);
      return (code == 0) ? 0 : ((1 << code) - 1);
   endfunction

endpackage

// File: rtl/rsv_thr_map.sv
module rsv_thr_map #(
   parameter int unsigned THR_W    = 3,
   parameter int unsigned N_LEVELS = 5,
   parameter int unsigned FALLBACK = 0
) (
   input  logic [THR_W-1:0] thr_sel,
   output logic [THR_W-1:0] thr_level
);
   localparam int unsigned CODES = 1 << THR_W;
   localparam logic [THR_W:0] NL = (THR_W+1)'(N_LEVELS);

   if (N_LEVELS > CODES) begin : g_bad_levels
      $error("rsv_thr_map: N_LEVELS exceeds code space");
   end
   if (FALLBACK >= N_LEVELS) begin : g_bad_fallback
      $error("rsv_thr_map: FALLBACK must name a valid level");
   end

   if (N_LEVELS == CODES) begin : g_full
      assign thr_level = thr_sel;
   end else begin : g_fold
      // codes past the last valid level fold onto the fallback level
      assign thr_level = ({1'b0, thr_sel} < NL) ? thr_sel : THR_W'(FALLBACK);
   end

   always_comb begin
      a_r1_level_valid: assert ({1'b0, thr_level} < NL);
   end

endmodule

// File: rtl/rsv_hold_ctl.sv
module rsv_hold_ctl #(
   parameter int unsigned HOLD_CYC = 8192
) (
   input  logic clk,
   input  logic arst_n,
   input  logic supply_ok,
   input  logic on_battery,
   output logic hold
);
   localparam int unsigned CW = $clog2(HOLD_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

   if (HOLD_CYC < 2) begin : g_bad_hold
      $error("rsv_hold_ctl: HOLD_CYC must be at least 2");
   end

   logic [CW-1:0] run_cnt;
   logic          good;

   assign good = supply_ok & ~on_battery;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hold    <= 1'b1;
         run_cnt <= '0;
      end else if (!supply_ok) begin
         hold    <= 1'b1;
         run_cnt <= '0;
      end else if (hold) begin
         if (!good) begin
            run_cnt <= '0;
         end else if (run_cnt == LAST) begin
            hold    <= 1'b0;
            run_cnt <= '0;
         end else begin
            run_cnt <= run_cnt + 1'b1;
         end
      end
   end

   a_r2_dip_holds: assert property (@(posedge clk) disable iff (!arst_n)
      !supply_ok |=> hold);

   a_r4_release_on_main: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(hold) |-> $past(supply_ok && !on_battery));

   a_r3_release_after_run: assert property (@(posedge clk) disable iff (!arst_n)
      $fell(hold) |-> ($past(run_cnt) == LAST));

endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog
   import rsv_pkg::*;
#(
   parameter int unsigned WD_UNIT  = 8192,
   parameter int unsigned HOLD_CYC = 8192
) (
   input  logic     clk,
   input  logic     arst_n,
   input  logic     kill,
   input  logic     on_battery,
   input  wd_mode_e mode,
   input  logic     kick,
   output logic     pulse
);
   localparam int unsigned MAXLIM = WD_UNIT * wd_mult(3);
   localparam int unsigned CW     = $clog2(MAXLIM + 1);
   localparam int unsigned PW     = $clog2(HOLD_CYC + 1);
   localparam logic [PW-1:0] PLAST = PW'(HOLD_CYC - 1);

   if (WD_UNIT < 2) begin : g_bad_unit
      $error("rsv_wdog: WD_UNIT must be at least 2");
   end

   logic [CW-1:0] lim_tab [4];
   for (genvar g = 0; g < 4; g++) begin : g_lim
      assign lim_tab[g] = CW'(WD_UNIT * wd_mult(g));
   end

   logic [CW-1:0] wcnt;
   logic [PW-1:0] pcnt;
   logic [CW-1:0] lim_sel;
   logic          armed;
   logic          expire;

   assign lim_sel = lim_tab[mode];
   assign armed   = (mode != WD_OFF) && !on_battery;
   assign expire  = ({1'b0, wcnt} + 1'b1) >= {1'b0, lim_sel};

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         wcnt  <= '0;
         pcnt  <= '0;
         pulse <= 1'b0;
      end else if (kill) begin
         wcnt  <= '0;
         pcnt  <= '0;
         pulse <= 1'b0;
      end else if (pulse) begin
         wcnt <= '0;
         if (pcnt == PLAST) begin
            pulse <= 1'b0;
            pcnt  <= '0;
         end else begin
            pcnt <= pcnt + 1'b1;
         end
      end else if (!armed || kick) begin
         wcnt <= '0;
      end else if (expire) begin
         pulse <= 1'b1;
         pcnt  <= '0;
         wcnt  <= '0;
      end else begin
         wcnt <= wcnt + 1'b1;
      end
   end

   a_r6_fire_needs_arm: assert property (@(posedge clk) disable iff (!arst_n)
      $rose(pulse) |-> $past(armed && !kick && !kill));

   a_r7_kick_restarts: assert property (@(posedge clk) disable iff (!arst_n)
      (!kill && !pulse && kick) |=> (wcnt == '0));

   a_r8_pulse_bounded: assert property (@(posedge clk) disable iff (!arst_n)
      pulse |-> (pcnt <= PLAST));

endmodule

// File: rtl/rsv_supervisor.sv
module rsv_supervisor
   import rsv_pkg::*;
#(
   parameter int unsigned HOLD_CYC = 8192,
   parameter int unsigned WD_UNIT  = 8192,
   parameter int unsigned THR_W    = 3,
   parameter int unsigned N_LEVELS = 5
) (
   input  logic             clk,
   input  logic             arst_n,
   input  logic             supply_ok,
   input  logic             on_battery,
   input  logic [THR_W-1:0] thr_sel,
   output logic [THR_W-1:0] thr_level,
   input  logic [1:0]       wd_mode,
   input  logic             wd_kick,
   input  logic             bus_ovr,
   output logic             rst_out_n,
   output logic             bus_en
);
   logic hold;
   logic pulse;

   rsv_thr_map #(
      .THR_W    (THR_W),
      .N_LEVELS (N_LEVELS),
      .FALLBACK (0)
   ) u_thr (
      .thr_sel   (thr_sel),
      .thr_level (thr_level)
   );

   rsv_hold_ctl #(
      .HOLD_CYC (HOLD_CYC)
   ) u_hold (
      .clk        (clk),
      .arst_n     (arst_n),
      .supply_ok  (supply_ok),
      .on_battery (on_battery),
      .hold       (hold)
   );

   rsv_wdog #(
      .WD_UNIT  (WD_UNIT),
      .HOLD_CYC (HOLD_CYC)
   ) u_wdog (
      .clk        (clk),
      .arst_n     (arst_n),
      .kill       (hold | ~supply_ok),
      .on_battery (on_battery),
      .mode       (wd_mode_e'(wd_mode)),
      .kick       (wd_kick),
      .pulse      (pulse)
   );

   assign rst_out_n = ~(hold | pulse);
   assign bus_en    = rst_out_n | bus_ovr;

   a_r10_dip_beats_wd: assert property (@(posedge clk) disable iff (!arst_n)
      !supply_ok |=> !rst_out_n);

   a_r9_bus_in_reset: assert property (@(posedge clk) disable iff (!arst_n)
      (hold && !bus_ovr) |-> !bus_en);

endmodule

// File: tb/rsv_supervisor_tb.sv
module rsv_supervisor_tb;
   localparam int HOLD = 20;
   localparam int UNIT = 12;

   logic       clk = 1'b0;
   logic       arst_n = 1'b0;
   logic       supply_ok = 1'b0;
   logic       on_battery = 1'b0;
   logic [2:0] thr_sel = 3'd0;
   logic [2:0] thr_level;
   logic [1:0] wd_mode = 2'b00;
   logic       wd_kick = 1'b0;
   logic       bus_ovr = 1'b0;
   logic       rst_out_n;
   logic       bus_en;

   int    n_vec = 0;
   int    n_bad = 0;
   int    cycles = 0;
   string cur_req = "R3";

   // behavioural reference state
   int m_hold = 1, m_run = 0, m_wd = 0, m_pl = 0;

   always #4 clk = ~clk;

   rsv_supervisor #(
      .HOLD_CYC (HOLD),
      .WD_UNIT  (UNIT)
   ) u_dut (
      .clk        (clk),
      .arst_n     (arst_n),
      .supply_ok  (supply_ok),
      .on_battery (on_battery),
      .thr_sel    (thr_sel),
      .thr_level  (thr_level),
      .wd_mode    (wd_mode),
      .wd_kick    (wd_kick),
      .bus_ovr    (bus_ovr),
      .rst_out_n  (rst_out_n),
      .bus_en     (bus_en)
   );

   function automatic int lim_of(input logic [1:0] m);
      return UNIT * ((1 << m) - 1);
   endfunction

   always @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         m_hold = 1; m_run = 0; m_wd = 0; m_pl = 0;
      end else if (!supply_ok) begin
         m_hold = 1; m_run = 0; m_wd = 0; m_pl = 0;
      end else if (m_hold != 0) begin
         if (on_battery) m_run = 0;
         else begin
            m_run++;
            if (m_run == HOLD) begin m_hold = 0; m_run = 0; end
         end
      end else if (m_pl > 0) begin
         m_pl--;
      end else if (on_battery || wd_mode == 2'b00 || wd_kick) begin
         m_wd = 0;
      end else if (m_wd + 1 >= lim_of(wd_mode)) begin
         m_pl = HOLD; m_wd = 0;
      end else begin
         m_wd++;
      end
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   // per-cycle comparison against the model, away from the edges
   always @(negedge clk) begin
      #2;
      cycles++;
      if (cycles > 150000) begin
         n_bad++;
         $display("FAIL watchdog: run hung, actual cycles=%0d expected<150000", cycles);
         summary();
      end
      begin
         logic       e_rst;
         logic [2:0] e_thr;
         e_rst = (m_hold == 0) && (m_pl == 0);
         e_thr = (thr_sel <= 3'd4) ? thr_sel : 3'd0;
         n_vec++;
         if (rst_out_n !== e_rst || bus_en !== (e_rst | bus_ovr) || thr_level !== e_thr) begin
            n_bad++;
            $display("FAIL %s cycle %0d: actual rst=%b bus=%b thr=%0d expected rst=%b bus=%b thr=%0d",
                     cur_req, cycles, rst_out_n, bus_en, thr_level, e_rst, e_rst | bus_ovr, e_thr);
         end
      end
   end

   task automatic chk(input string req, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual=%b expected=%b", req, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      step(2);
      chk("R3 reset state", rst_out_n, 1'b0);
      chk("R9 reset state bus", bus_en, 1'b0);
      arst_n = 1'b1;
      step(2);
      // R1: threshold fold
      cur_req = "R1";
      for (int s = 0; s < 8; s++) begin
         thr_sel = 3'(s);
         #1;
         n_vec++;
         if (thr_level !== ((s <= 4) ? 3'(s) : 3'd0)) begin
            n_bad++;
            $display("FAIL R1: sel=%0d actual=%0d expected=%0d", s, thr_level, (s <= 4) ? s : 0);
         end
         step(1);
      end
      // R9: override while held
      cur_req = "R9";
      bus_ovr = 1'b1; #1;
      chk("R9 override in reset", bus_en, 1'b1);
      bus_ovr = 1'b0; #1;
      chk("R9 gated in reset", bus_en, 1'b0);
      // R3: release after HOLD good edges, interrupted once
      cur_req = "R3";
      supply_ok = 1'b1;
      step(10);
      supply_ok = 1'b0;
      step(1);
      supply_ok = 1'b1;
      step(HOLD - 1);
      chk("R3 still held", rst_out_n, 1'b0);
      step(1);
      chk("R3 released", rst_out_n, 1'b1);
      chk("R9 bus on released", bus_en, 1'b1);
      // R2 / R4: dip then battery blocks release
      cur_req = "R4";
      supply_ok = 1'b0;
      step(1);
      chk("R2 dip asserts", rst_out_n, 1'b0);
      supply_ok = 1'b1; on_battery = 1'b1;
      step(3 * HOLD);
      chk("R4 battery holds", rst_out_n, 1'b0);
      on_battery = 1'b0;
      step(HOLD);
      chk("R4 release on main", rst_out_n, 1'b1);
      // R6: watchdog off, then battery with mode set
      cur_req = "R6";
      step(200);
      chk("R6 off never fires", rst_out_n, 1'b1);
      on_battery = 1'b1; wd_mode = 2'b01;
      step(5 * UNIT);
      chk("R6 battery freezes wd", rst_out_n, 1'b1);
      on_battery = 1'b0;
      // R5 / R8: short timeout and pulse length
      cur_req = "R8";
      step(UNIT - 1);
      chk("R5 short not yet", rst_out_n, 1'b1);
      wd_kick = 1'b1;      // ignored during pulse later; here kick at edge UNIT
      step(1);
      chk("R7 kick on expiry edge wins", rst_out_n, 1'b1);
      wd_kick = 1'b0;
      step(UNIT - 1);
      chk("R5 short before expiry", rst_out_n, 1'b1);
      step(1);
      chk("R8 pulse starts", rst_out_n, 1'b0);
      wd_kick = 1'b1;
      step(HOLD - 1);
      chk("R8 pulse holds with kicks", rst_out_n, 1'b0);
      wd_kick = 1'b0;
      step(1);
      chk("R8 pulse ends", rst_out_n, 1'b1);
      step(UNIT - 1);
      chk("R8 restart from zero", rst_out_n, 1'b1);
      step(1);
      chk("R8 second expiry", rst_out_n, 1'b0);
      step(HOLD);
      // R5: mid and long
      cur_req = "R5";
      wd_mode = 2'b10;
      step(3 * UNIT - 1);
      chk("R5 mid before", rst_out_n, 1'b1);
      step(1);
      chk("R5 mid expiry", rst_out_n, 1'b0);
      wd_mode = 2'b11;
      step(HOLD);
      step(7 * UNIT - 1);
      chk("R5 long before", rst_out_n, 1'b1);
      step(1);
      chk("R5 long expiry", rst_out_n, 1'b0);
      wd_mode = 2'b01;
      step(HOLD);
      // R10: dip on the expiry edge
      cur_req = "R10";
      step(UNIT - 1);
      supply_ok = 1'b0;
      step(1);
      chk("R10 dip on expiry", rst_out_n, 1'b0);
      supply_ok = 1'b1;
      step(HOLD - 1);
      chk("R10 still held", rst_out_n, 1'b0);
      step(1);
      chk("R10 normal release", rst_out_n, 1'b1);
      // random phase, judged by the per-cycle model
      cur_req = "R7";
      for (int i = 0; i < 6000; i++) begin
         if ($urandom_range(0, 199) == 0) supply_ok = ~supply_ok;
         else if (!supply_ok && $urandom_range(0, 9) == 0) supply_ok = 1'b1;
         if ($urandom_range(0, 299) == 0) on_battery = ~on_battery;
         wd_kick = ($urandom_range(0, 14) == 0);
         if ($urandom_range(0, 249) == 0) wd_mode = 2'($urandom_range(0, 3));
         if ($urandom_range(0, 49) == 0) bus_ovr = ~bus_ovr;
         if ($urandom_range(0, 99) == 0) thr_sel = 3'($urandom_range(0, 7));
         step(1);
      end
      summary();
   end
endmodule